// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one self-running DMA channel. Software writes the memory address of a descriptor into the base register, rings the doorbell and then turns the channel on. The channel fetches a four-word descriptor from memory. It then copies a number of fixed-size blocks from a source address to a target address. Each block is 1, 2, 4, 16, 32, 64 or 128 bytes. Either address can step forward after each block or stay fixed, which suits a peripheral data register.

A descriptor can name a follow-on descriptor. The link is a byte offset from the latched base, stored in 16-byte units, so a chain of any length or a closed ring can be built in memory. When a descriptor without a link finishes, the channel reports transfer end and, if that descriptor asks for it, raises an interrupt. A misaligned descriptor is refused with an address-error flag before any data moves. While the channel runs, the number of blocks still to move for the current descriptor can be read at any time.

Memory is reached through a word-wide read port with one cycle of latency and a word-wide write port with byte enables. Every beat moves one 32-bit word. The engine is never held off by a peripheral.

Top module: `dmach_engine`

## Requirements
- R1: On start the channel reads four words from the descriptor address, in this order: command, source address, target address, count/link. In the count/link word, bits 23:0 are the block count and bits 31:24 are the link offset.
- R2: A transfer starts only after three steps: a base write, a doorbell pulse, and a status write of 0x03 (bit 0 enable, bit 1 keeps the pending doorbell). With enable set but no doorbell, nothing is read or written.
- R3: Command bits 10:8 pick the block size. Code 0 is 4 bytes, 1 is 1 byte, 2 is 2 bytes, 3 is 16 bytes, 4 is 32 bytes, 5 is 64 bytes and 6 is 128 bytes. A block of 4 bytes or more moves as consecutive words, and nothing past the last block is written.
- R4: Command bit 23 steps the source address by one block after each block, and bit 22 does the same for the target address. A cleared bit keeps that address at the same location for every block.
- R5: If command bit 0 (link) is set, the next descriptor is fetched from base + 16 × offset once the current one finishes. An offset of 0 returns to the first descriptor and forms a ring that keeps running.
- R6: When a descriptor with bit 0 clear finishes, status bit 3 (end) sets and bit 0 (enable) clears. The irq output is high while end is set and bit 1 of that last command was set.
- R7: Linked descriptors never set the end flag or raise irq, whatever their bit 1 holds.
- R8: If the source or target address is not a multiple of the block size, status bits 4 (address error) and 2 (halt) set, enable clears, and no memory write takes place.
- R9: remain_cnt loads the block count when a descriptor is fetched and drops by one per finished block. It reads 0 after a completed descriptor.
- R10: Status is 0 after reset. Writing 0 to status stops the channel, clears every flag and irq, and no memory write follows.
- R11: For 1- and 2-byte blocks, the byte is moved from its source lane to its target lane, and the byte enables cover only the target bytes.
- R12: A descriptor with a block count of 0 moves nothing and finishes like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_base_we | input | 1 | Write strobe for the descriptor base register |
| desc_base_wdata | input | AW | Descriptor base address |
| doorbell | input | 1 | One-cycle pulse that arms a start |
| ctl_we | input | 1 | Write strobe for the status register |
| ctl_wdata | input | 5 | Status write value: {addr err, end, halt, armed, enable} |
| ctl_status | output | 5 | Status read value, same bit layout |
| remain_cnt | output | 24 | Blocks still to move in the current descriptor |
| irq | output | 1 | Transfer-end interrupt, level |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read byte address, word aligned |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write byte address, word aligned |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Write byte enables |

## Verification
A wrong field capture during the descriptor fetch shows up within a few cycles. The block count appears on remain_cnt as soon as the fourth word arrives, and a bad source or target is visible at the first write beat. A broken beat or block counter moves the wrong words or writes past the end, which shows in memory when the chain ends. A wrong link or end decision shows as a missing or spurious end flag or irq. A channel that fails to stop can be seen because writes keep coming after status is cleared.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_READ, S_WRITE, S_ENDD
    } st_e;

    localparam int CMD_LINK = 0;
    localparam int CMD_TIE  = 1;
    localparam int CMD_DINC = 22;
    localparam int CMD_SINC = 23;
    localparam int SIZE_LO  = 8;
endpackage

// File: rtl/dmach_size_dec.sv
module dmach_size_dec (
    input  logic [2:0] code,
    output logic [7:0] bytes,
    output logic [4:0] beats_m1,
    output logic [6:0] amask
);
    always_comb begin
        case (code)
            3'd0:    bytes = 8'd4;
            3'd1:    bytes = 8'd1;
            3'd2:    bytes = 8'd2;
            3'd3:    bytes = 8'd16;
            3'd4:    bytes = 8'd32;
            3'd5:    bytes = 8'd64;
            default: bytes = 8'd128;
        endcase
        beats_m1 = (bytes >= 8'd4) ? 5'(bytes[7:2] - 6'd1) : 5'd0;
        amask    = 7'(bytes - 8'd1);
    end
endmodule

// File: rtl/dmach_lane.sv
module dmach_lane #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] rd_word,
    input  logic [1:0]         ssh,
    input  logic [1:0]         dsh,
    input  logic [1:0]         nb,      // 0: full word, 1: one byte, 2: two bytes
    output logic [8*LANES-1:0] wr_word,
    output logic [LANES-1:0]   wr_be
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [1:0] sel;
        always_comb begin
            sel = 2'(j) - dsh + ssh;
            wr_word[8*j +: 8] = rd_word[8*sel +: 8];
        end
    end

    always_comb begin
        case (nb)
            2'd1:    wr_be = LANES'(4'b0001 << dsh);
            2'd2:    wr_be = LANES'(4'b0011 << dsh);
            default: wr_be = '1;
        endcase
    end
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_base_we,
    input  logic [AW-1:0] desc_base_wdata,
    input  logic          doorbell,
    input  logic          ctl_we,
    input  logic [4:0]    ctl_wdata,
    output logic [4:0]    ctl_status,
    output logic [23:0]   remain_cnt,
    output logic          irq,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [31:0]   mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [31:0]   mem_wr_data,
    output logic [3:0]    mem_wr_be
);
    localparam int CW = 24;

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] base;
        logic [AW-1:0] fptr;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] remain;
        logic [7:0]    link;
        logic [2:0]    size;
        logic          sinc;
        logic          dinc;
        logic          lnk;
        logic          tie_c;
        logic [2:0]    idx;
        logic [4:0]    beat;
        logic          en;
        logic          db;
        logic          hlt;
        logic          tt;
        logic          ar;
        logic          tie;
    } regs_t;

    regs_t r_q, r_d;

    logic [7:0] blk_bytes;
    logic [4:0] beats_m1;
    logic [6:0] amask;
    logic       narrow;
    logic [1:0] nb;
    logic [31:0] lane_word;
    logic [3:0]  lane_be;

    dmach_size_dec u_size (
        .code     (r_q.size),
        .bytes    (blk_bytes),
        .beats_m1 (beats_m1),
        .amask    (amask)
    );

    assign narrow = (blk_bytes < 8'd4);
    assign nb     = narrow ? blk_bytes[1:0] : 2'd0;

    dmach_lane #(.LANES(4)) u_lane (
        .rd_word (mem_rd_data),
        .ssh     (narrow ? r_q.src[1:0] : 2'd0),
        .dsh     (narrow ? r_q.dst[1:0] : 2'd0),
        .nb      (nb),
        .wr_word (lane_word),
        .wr_be   (lane_be)
    );

    always_comb begin
        r_d         = r_q;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = '0;
        mem_wr_data = '0;
        mem_wr_be   = '0;

        if (desc_base_we) r_d.base = desc_base_wdata;
        if (doorbell)     r_d.db   = 1'b1;

        case (r_q.st)
            S_IDLE: begin
                if (r_q.en && r_q.db) begin
                    r_d.st   = S_FETCH;
                    r_d.idx  = '0;
                    r_d.fptr = r_q.base;
                    r_d.db   = doorbell;
                end
            end
            S_FETCH: begin
                if (r_q.idx < 3'd4) begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = r_q.fptr + {{(AW-5){1'b0}}, r_q.idx, 2'b00};
                end
                case (r_q.idx)
                    3'd1: begin
                        r_d.lnk   = mem_rd_data[CMD_LINK];
                        r_d.tie_c = mem_rd_data[CMD_TIE];
                        r_d.dinc  = mem_rd_data[CMD_DINC];
                        r_d.sinc  = mem_rd_data[CMD_SINC];
                        r_d.size  = mem_rd_data[SIZE_LO +: 3];
                    end
                    3'd2: r_d.src = AW'(mem_rd_data);
                    3'd3: r_d.dst = AW'(mem_rd_data);
                    3'd4: {r_d.link, r_d.remain} = mem_rd_data;
                    default: ;
                endcase
                r_d.idx = r_q.idx + 3'd1;
                if (r_q.idx == 3'd4) r_d.st = S_CHECK;
            end
            S_CHECK: begin
                r_d.beat = '0;
                if (((r_q.src | r_q.dst) & {{(AW-7){1'b0}}, amask}) != '0) begin
                    r_d.ar  = 1'b1;
                    r_d.hlt = 1'b1;
                    r_d.en  = 1'b0;
                    r_d.st  = S_IDLE;
                end else if (r_q.remain == '0) begin
                    r_d.st = S_ENDD;
                end else begin
                    r_d.st = S_READ;
                end
            end
            S_READ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = {r_q.src[AW-1:2], 2'b00} + {{(AW-7){1'b0}}, r_q.beat, 2'b00};
                r_d.st      = S_WRITE;
            end
            S_WRITE: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = {r_q.dst[AW-1:2], 2'b00} + {{(AW-7){1'b0}}, r_q.beat, 2'b00};
                mem_wr_data = lane_word;
                mem_wr_be   = lane_be;
                if (r_q.beat == beats_m1) begin
                    r_d.beat   = '0;
                    r_d.remain = r_q.remain - 1'b1;
                    if (r_q.sinc) r_d.src = r_q.src + {{(AW-8){1'b0}}, blk_bytes};
                    if (r_q.dinc) r_d.dst = r_q.dst + {{(AW-8){1'b0}}, blk_bytes};
                    r_d.st = (r_q.remain == CW'(1)) ? S_ENDD : S_READ;
                end else begin
                    r_d.beat = r_q.beat + 5'd1;
                    r_d.st   = S_READ;
                end
            end
            S_ENDD: begin
                if (r_q.lnk) begin
                    r_d.fptr = r_q.base + {{(AW-12){1'b0}}, r_q.link, 4'b0000};
                    r_d.idx  = '0;
                    r_d.st   = S_FETCH;
                end else begin
                    r_d.tt  = 1'b1;
                    r_d.tie = r_q.tie_c;
                    r_d.en  = 1'b0;
                    r_d.st  = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (ctl_we) begin
            r_d.en  = ctl_wdata[0];
            r_d.db  = ctl_wdata[1] & (r_q.db | doorbell);
            r_d.hlt = ctl_wdata[2];
            r_d.tt  = ctl_wdata[3];
            r_d.ar  = ctl_wdata[4];
            if (!ctl_wdata[0]) r_d.st = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_status = {r_q.ar, r_q.tt, r_q.hlt, r_q.db, r_q.en};
    assign remain_cnt = r_q.remain;
    assign irq        = r_q.tt & r_q.tie;
endmodule

// File: rtl/dmach_engine_chk.sv
module dmach_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic [4:0]  ctl_status,
    input logic [23:0] remain_cnt,
    input logic        irq,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [3:0]  mem_wr_be
);
    // R10: memory is written only while the channel is enabled
    p_wr_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ctl_status[0]);

    // R1: fetch/read and write beats never share a cycle
    p_rd_wr_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R6: irq only with the end flag
    p_irq_implies_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_status[3]);

    // R8: an address error raised by the engine leaves the channel disabled
    p_err_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_status[4]) && !$past(ctl_we)) |-> !ctl_status[0]);

    // R9: remaining count holds while the channel stays off
    p_idle_count_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_status[0] && $past(!ctl_status[0])) |-> $stable(remain_cnt));

    // R11: every write carries at least one byte enable
    p_be_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wr_be) > 0));
endmodule

bind dmach_engine dmach_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_status (ctl_status),
    .remain_cnt (remain_cnt),
    .irq        (irq),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_be  (mem_wr_be)
);

// File: tb/dmach_engine_tb.sv
`timescale 1ns/1ps
module dmach_engine_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_base_we = 1'b0;
    logic [AW-1:0] desc_base_wdata = '0;
    logic          doorbell = 1'b0;
    logic          ctl_we = 1'b0;
    logic [4:0]    ctl_wdata = '0;
    logic [4:0]    ctl_status;
    logic [23:0]   remain_cnt;
    logic          irq;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data = '0;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [31:0]   mem_wr_data;
    logic [3:0]    mem_wr_be;

    logic [31:0] mem [0:255];
    int wr_count = 0;
    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    dmach_engine #(.AW(AW)) u_dut (.*);

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
        if (mem_wr_en) begin
            wr_count <= wr_count + 1;
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) mem[mem_wr_addr[9:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit sinc, input bit dinc, input logic [2:0] sz,
                                          input bit lnk, input bit tie);
        return (32'(sinc) << 23) | (32'(dinc) << 22) | (32'(sz) << 8) | (32'(tie) << 1) | 32'(lnk);
    endfunction

    task automatic put_desc(input int a, input logic [31:0] cmd, input logic [31:0] s,
                            input logic [31:0] d, input logic [23:0] cnt, input logic [7:0] lnk);
        mem[a/4]     = cmd;
        mem[a/4 + 1] = s;
        mem[a/4 + 2] = d;
        mem[a/4 + 3] = {lnk, cnt};
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < 64; i++)
            mem[64 + i] = {8'(16 + 4*i + 3), 8'(16 + 4*i + 2), 8'(16 + 4*i + 1), 8'(16 + 4*i)};
    endtask

    task automatic ctl_write(input logic [4:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic kick(input logic [31:0] base);
        @(negedge clk); desc_base_we = 1'b1; desc_base_wdata = base;
        @(negedge clk); desc_base_we = 1'b0; doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0; ctl_we = 1'b1; ctl_wdata = 5'b00011;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (ctl_status[0] && n < 3000) begin @(negedge clk); n++; end
        chk({tag, " finishes"}, 32'(ctl_status[0]), 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 reset status", 32'(ctl_status), 32'h0);
        chk("R10 reset irq", 32'(irq), 32'h0);
        chk("R9 reset remain", 32'(remain_cnt), 32'h0);
        chk("R10 reset mem idle", 32'({mem_rd_en, mem_wr_en}), 32'h0);
    endtask

    task automatic t_no_doorbell();
        int w0;
        init_mem();
        put_desc(32, mk_cmd(1, 1, 0, 0, 1), 32'h100, 32'h200, 24'd2, 8'd0);
        w0 = wr_count;
        @(negedge clk); desc_base_we = 1'b1; desc_base_wdata = 32'h20;
        @(negedge clk); desc_base_we = 1'b0;
        ctl_write(5'b00011);
        repeat (30) @(negedge clk);
        chk("R2 no writes without doorbell", 32'(wr_count - w0), 32'h0);
        chk("R2 status enabled unarmed", 32'(ctl_status), 32'h01);
        chk("R2 target untouched", mem[128], 32'h0);
        ctl_write(5'b00000);
    endtask

    task automatic t_single();
        int n = 0;
        init_mem();
        put_desc(32, mk_cmd(1, 1, 0, 0, 1), 32'h100, 32'h200, 24'd4, 8'd0);
        kick(32'h20);
        while (remain_cnt == 0 && n < 40) begin @(negedge clk); n++; end
        chk("R9 remain loaded", 32'(remain_cnt), 32'd4);
        wait_idle("R1 single");
        for (int i = 0; i < 4; i++) chk("R1 word copied", mem[128 + i], mem[64 + i]);
        chk("R3 no overrun", mem[132], 32'h0);
        chk("R6 end status", 32'(ctl_status), 32'h08);
        chk("R6 irq", 32'(irq), 32'h1);
        chk("R9 remain zero", 32'(remain_cnt), 32'h0);
        ctl_write(5'b00000);
        chk("R10 cleared status", 32'(ctl_status), 32'h0);
        chk("R10 irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_wide();
        init_mem();
        put_desc(32, mk_cmd(1, 1, 3, 0, 0), 32'h110, 32'h220, 24'd2, 8'd0);
        kick(32'h20);
        wait_idle("R3 16B");
        for (int i = 0; i < 8; i++) chk("R3 16B block words", mem[136 + i], mem[68 + i]);
        chk("R3 16B no overrun", mem[144], 32'h0);
        chk("R6 end without irq", 32'({irq, ctl_status}), 32'h08);
        ctl_write(5'b00000);
    endtask

    task automatic t_chain();
        init_mem();
        put_desc(32, mk_cmd(1, 1, 0, 1, 1), 32'h100, 32'h200, 24'd2, 8'd2);
        put_desc(64, mk_cmd(1, 1, 0, 0, 0), 32'h180, 32'h240, 24'd1, 8'd0);
        kick(32'h20);
        wait_idle("R5 chain");
        chk("R5 first desc w0", mem[128], mem[64]);
        chk("R5 first desc w1", mem[129], mem[65]);
        chk("R5 linked desc", mem[144], mem[96]);
        chk("R7 end after chain", 32'(ctl_status), 32'h08);
        chk("R7 no irq from linked tie", 32'(irq), 32'h0);
        ctl_write(5'b00000);
    endtask

    task automatic t_ring();
        int w0;
        init_mem();
        put_desc(32, mk_cmd(1, 1, 0, 1, 1), 32'h100, 32'h200, 24'd2, 8'd0);
        kick(32'h20);
        repeat (300) @(negedge clk);
        chk("R5 ring still running", 32'(ctl_status[0]), 32'h1);
        chk("R7 ring never ends", 32'({irq, ctl_status[3]}), 32'h0);
        chk("R5 ring copied", mem[129], mem[65]);
        ctl_write(5'b00000);
        w0 = wr_count;
        repeat (20) @(negedge clk);
        chk("R10 no writes after stop", 32'(wr_count - w0), 32'h0);
        chk("R10 stopped status", 32'(ctl_status), 32'h0);
    endtask

    task automatic t_misalign();
        int w0;
        init_mem();
        put_desc(32, mk_cmd(1, 1, 0, 0, 1), 32'h102, 32'h200, 24'd1, 8'd0);
        w0 = wr_count;
        kick(32'h20);
        wait_idle("R8 misalign");
        chk("R8 error status", 32'(ctl_status), 32'h14);
        chk("R8 no write", 32'(wr_count - w0), 32'h0);
        chk("R8 target untouched", mem[128], 32'h0);
        ctl_write(5'b00000);
    endtask

    task automatic t_bytes();
        init_mem();
        put_desc(32, mk_cmd(1, 1, 1, 0, 1), 32'h101, 32'h206, 24'd3, 8'd0);
        kick(32'h20);
        wait_idle("R11 bytes");
        chk("R11 lanes word 1", mem[129], 32'h1211_0000);
        chk("R11 lanes word 2", mem[130], 32'h0000_0013);
        chk("R11 neighbour untouched", mem[128], 32'h0);
        ctl_write(5'b00000);
    endtask

    task automatic t_fixed();
        init_mem();
        put_desc(32, mk_cmd(1, 0, 0, 0, 0), 32'h100, 32'h200, 24'd3, 8'd0);
        kick(32'h20);
        wait_idle("R4 fixed");
        chk("R4 fixed target holds last", mem[128], mem[66]);
        chk("R4 fixed target no step", mem[129], 32'h0);
        ctl_write(5'b00000);
    endtask

    task automatic t_zero();
        int w0;
        init_mem();
        put_desc(32, mk_cmd(1, 1, 0, 0, 1), 32'h100, 32'h200, 24'd0, 8'd0);
        w0 = wr_count;
        kick(32'h20);
        wait_idle("R12 zero");
        chk("R12 no writes", 32'(wr_count - w0), 32'h0);
        chk("R12 end and irq", 32'({irq, ctl_status}), 32'h28);
        ctl_write(5'b00000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        init_mem();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_doorbell();
        t_single();
        t_wide();
        t_chain();
        t_ring();
        t_misalign();
        t_bytes();
        t_fixed();
        t_zero();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule